// File: doc/BRIEF.md
# Staged-Wakeup Compacting Issue Queue

This block holds waiting instructions for an out-of-order core and tracks when their two source operands become available. Each slot keeps two source tags, a ready flag for each, a destination tag and a valid flag. A producer announces a finished result by broadcasting its tag. The broadcast does not reach the whole queue in one cycle. It moves from the head group of slots to the tail group through one tag register per group, so each group compares it one cycle after the group in front of it.

New instructions enter at the tail slot, one per cycle. Valid entries drift toward the head, one slot per cycle, to fill holes left by issued entries. The older an entry is, the nearer it sits to the head. An entry that crosses from one group into the next compares against the broadcast stages of both groups in that cycle. Because of this it never misses a tag that is still travelling down the queue. Each slot exposes a ready flag to outside select logic, and an issue strobe per slot removes the entry.

Top module: `iqw_wakeup_queue`

## Requirements
- R1: While reset is held, and on the first cycle after it, every slot is empty: slot_valid, slot_ready and full are all zero.
- R2: When alloc_valid is high and full is low, the instruction is written into slot DEPTH-1 (slot 31) at the clock edge. Its destination tag appears at slot_dst bits [31*6 +: 6].
- R3: Each valid entry that has an empty slot (before this cycle's issues) at a lower index moves exactly one slot toward index 0 per clock edge. All other entries stay in place, and relative order is preserved.
- R4: full is high exactly when all 32 slots are valid. An allocation presented while full is high is dropped and changes no slot.
- R5: An issue strobe on a valid slot removes that entry at the next edge. That slot is not refilled by the entry above it at that same edge; the entry above moves in at the following edge.
- R6: A tag broadcast (bc_valid high) presented in cycle t is compared by group g (slots 8g to 8g+7, group 0 at the head) at the edge ending cycle t+g. A matching source becomes ready from then on.
- R7: slot_ready of a slot is high exactly when the slot is valid and both of its source ready flags are set. Once set, a ready flag stays set while the entry remains in the queue.
- R8: The source ready flags supplied with an allocation are stored as given, so an instruction allocated with both flags set is ready in slot 31 right after the allocating edge.
- R9: An entry moving across a group boundary in a cycle compares against the broadcast stage of both the group it leaves and the group it enters, so it catches every tag still in flight.
- R10: An allocated entry is woken by a matching broadcast presented three or fewer cycles before its allocation, or at any time later. A broadcast four or more cycles earlier is not seen and must be covered by the flags supplied at allocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocation request at the tail |
| alloc_src_a | input | 6 | First source tag |
| alloc_src_a_rdy | input | 1 | First source already available |
| alloc_src_b | input | 6 | Second source tag |
| alloc_src_b_rdy | input | 1 | Second source already available |
| alloc_dst | input | 6 | Destination tag |
| full | output | 1 | All slots occupied; allocation is dropped |
| bc_valid | input | 1 | Result tag broadcast present |
| bc_tag | input | 6 | Broadcast result tag |
| issue | input | 32 | Per-slot issue strobe, bit j removes slot j |
| slot_valid | output | 32 | Per-slot occupancy |
| slot_ready | output | 32 | Per-slot ready to issue |
| slot_dst | output | 192 | Per-slot destination tag, slot j at bits [6j +: 6] |

## Verification
A single entry allocated into an empty queue shows the tail write and the one-slot-per-edge drift. A pair of entries parked at the head, with the front one issued, separates the "removed this edge" behaviour from the "refilled next edge" behaviour. A full queue waiting on one tag, woken by a single broadcast, shows the group-by-group wake timing, because the ready vector fills one group per cycle. A lone entry timed to cross from group 3 into group 2 just as the tag passes between them detects a missing crossing check. Allocations placed three and four cycles after a broadcast mark the edge of the catch window. A long seeded random run, with mixed allocations, broadcasts and issues, is compared every cycle against a cycle model in the bench.

// File: rtl/iqw_pkg.sv
package iqw_pkg;

    localparam int TAG_W = 6;

    typedef logic [TAG_W-1:0] tag_t;

    typedef struct packed {
        logic vld;
        logic ra;
        logic rb;
        tag_t sa;
        tag_t sb;
        tag_t dst;
    } entry_t;

    typedef struct packed {
        logic vld;
        tag_t tag;
    } bcast_t;

    // Set source ready flags whose tag matches a live broadcast stage.
    function automatic entry_t wake_entry(entry_t e, bcast_t b);
        entry_t r;
        r = e;
        if (b.vld && (b.tag == e.sa)) r.ra = 1'b1;
        if (b.vld && (b.tag == e.sb)) r.rb = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/iqw_bcast_pipe.sv
module iqw_bcast_pipe
    import iqw_pkg::*;
#(
    parameter int NSTG = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  bcast_t bc_in,
    output bcast_t stg [NSTG]
);
    // Stage 0 is the live broadcast; each later stage is one cycle older.
    assign stg[0] = bc_in;

    genvar k;
    generate
        for (k = 1; k < NSTG; k++) begin : g_stage
            bcast_t r;
            always_ff @(posedge clk) begin
                if (rst) r <= '0;
                else     r <= stg[k-1];
            end
            assign stg[k] = r;
        end
    endgenerate
endmodule

// File: rtl/iqw_hole_scan.sv
module iqw_hole_scan #(
    parameter int DEPTH = 32
) (
    input  logic [DEPTH-1:0] vld,
    output logic [DEPTH-1:0] take_up
);
    // take_up[j]: some slot at index <= j is empty, so slot j pulls from j+1.
    always_comb begin
        logic acc;
        acc = 1'b0;
        for (int j = 0; j < DEPTH; j++) begin
            acc        = acc | ~vld[j];
            take_up[j] = acc;
        end
    end
endmodule

// File: rtl/iqw_slot.sv
module iqw_slot
    import iqw_pkg::*;
#(
    parameter bit CROSS = 1'b0
) (
    input  logic   clk,
    input  logic   rst,
    input  entry_t upper,
    input  logic   take_up,
    input  logic   kill_own,
    input  logic   kill_up,
    input  bcast_t st_own,
    input  bcast_t st_up,
    output entry_t q
);
    entry_t cand;
    entry_t nxt;

    always_comb begin
        cand     = take_up ? upper : q;
        cand.vld = cand.vld & ~(take_up ? kill_up : kill_own);
        nxt      = wake_entry(cand, st_own);
        // A mover from the neighbouring group also checks that group's stage.
        if (CROSS && take_up) nxt = wake_entry(nxt, st_up);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end
endmodule

// File: rtl/iqw_wakeup_queue.sv
module iqw_wakeup_queue
    import iqw_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int GROUP = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   alloc_valid,
    input  logic [TAG_W-1:0]       alloc_src_a,
    input  logic                   alloc_src_a_rdy,
    input  logic [TAG_W-1:0]       alloc_src_b,
    input  logic                   alloc_src_b_rdy,
    input  logic [TAG_W-1:0]       alloc_dst,
    output logic                   full,
    input  logic                   bc_valid,
    input  logic [TAG_W-1:0]       bc_tag,
    input  logic [DEPTH-1:0]       issue,
    output logic [DEPTH-1:0]       slot_valid,
    output logic [DEPTH-1:0]       slot_ready,
    output logic [DEPTH*TAG_W-1:0] slot_dst
);
    localparam int NGRP = DEPTH / GROUP;

    entry_t           q [DEPTH];
    bcast_t           stg [NGRP];
    bcast_t           bc_in;
    entry_t           alloc_e;
    logic [DEPTH-1:0] take_up;

    assign bc_in.vld = bc_valid;
    assign bc_in.tag = bc_tag;

    iqw_bcast_pipe #(.NSTG(NGRP)) u_pipe (
        .clk  (clk),
        .rst  (rst),
        .bc_in(bc_in),
        .stg  (stg)
    );

    iqw_hole_scan #(.DEPTH(DEPTH)) u_scan (
        .vld    (slot_valid),
        .take_up(take_up)
    );

    assign full = ~take_up[DEPTH-1];

    always_comb begin
        alloc_e.vld = alloc_valid & ~full;
        alloc_e.ra  = alloc_src_a_rdy;
        alloc_e.rb  = alloc_src_b_rdy;
        alloc_e.sa  = alloc_src_a;
        alloc_e.sb  = alloc_src_b;
        alloc_e.dst = alloc_dst;
    end

    genvar j;
    generate
        for (j = 0; j < DEPTH; j++) begin : g_slot
            localparam int GO = j / GROUP;
            if (j == DEPTH - 1) begin : g_tail
                iqw_slot #(.CROSS(1'b0)) u_slot (
                    .clk(clk), .rst(rst),
                    .upper(alloc_e), .take_up(take_up[j]),
                    .kill_own(issue[j]), .kill_up(1'b0),
                    .st_own(stg[GO]), .st_up(stg[GO]),
                    .q(q[j])
                );
            end else begin : g_body
                localparam int GU = (j + 1) / GROUP;
                iqw_slot #(.CROSS(GU != GO)) u_slot (
                    .clk(clk), .rst(rst),
                    .upper(q[j+1]), .take_up(take_up[j]),
                    .kill_own(issue[j]), .kill_up(issue[j+1]),
                    .st_own(stg[GO]), .st_up(stg[GU]),
                    .q(q[j])
                );
            end
            assign slot_valid[j]               = q[j].vld;
            assign slot_ready[j]               = q[j].vld & q[j].ra & q[j].rb;
            assign slot_dst[j*TAG_W +: TAG_W]  = q[j].dst;
        end
    endgenerate
endmodule

// File: rtl/iqw_checker.sv
module iqw_checker #(
    parameter int DEPTH = 32,
    parameter int TAG_W = 6
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   full,
    input logic [DEPTH-1:0]       issue,
    input logic [DEPTH-1:0]       slot_valid,
    input logic [DEPTH-1:0]       slot_ready,
    input logic [DEPTH*TAG_W-1:0] slot_dst
);
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    always @(posedge clk) begin
        if (rst_q === 1'b1)
            AST_RESET_EMPTY: assert (slot_valid == '0 && slot_ready == '0); // R1
    end

    AST_FULL_ALL_VALID: assert property (@(posedge clk) disable iff (rst)
        full == (&slot_valid)); // R4

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (full && issue == '0) |=> (full && $stable(slot_dst))); // R4

    AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        (slot_ready & ~slot_valid) == '0); // R7

    AST_READY_STICKS: assert property (@(posedge clk) disable iff (rst)
        (slot_ready[0] && !issue[0]) |=> slot_ready[0]); // R7

    AST_HEAD_REFILL: assert property (@(posedge clk) disable iff (rst)
        (!slot_valid[0] && slot_valid[1] && !issue[1]) |=>
        (slot_valid[0] && slot_dst[TAG_W-1:0] == $past(slot_dst[2*TAG_W-1:TAG_W]))); // R3

    AST_ISSUE_REMOVES: assert property (@(posedge clk) disable iff (rst)
        (slot_valid[0] && issue[0]) |=> !slot_valid[0]); // R5
endmodule

bind iqw_wakeup_queue iqw_checker #(.DEPTH(DEPTH), .TAG_W(iqw_pkg::TAG_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .full      (full),
    .issue     (issue),
    .slot_valid(slot_valid),
    .slot_ready(slot_ready),
    .slot_dst  (slot_dst)
);

// File: tb/tb_iqw_wakeup_queue.sv
module tb_iqw_wakeup_queue;
    localparam int CLK_PERIOD = 10;
    localparam int D  = 32;
    localparam int G  = 8;
    localparam int TW = 6;
    localparam int NG = D / G;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          alloc_valid = 1'b0;
    logic [TW-1:0] alloc_src_a = '0, alloc_src_b = '0, alloc_dst = '0;
    logic          alloc_src_a_rdy = 1'b0, alloc_src_b_rdy = 1'b0;
    logic          full;
    logic          bc_valid = 1'b0;
    logic [TW-1:0] bc_tag = '0;
    logic [D-1:0]  issue = '0;
    logic [D-1:0]  slot_valid, slot_ready;
    logic [D*TW-1:0] slot_dst;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    iqw_wakeup_queue #(.DEPTH(D), .GROUP(G)) dut (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_src_a(alloc_src_a),
        .alloc_src_a_rdy(alloc_src_a_rdy), .alloc_src_b(alloc_src_b),
        .alloc_src_b_rdy(alloc_src_b_rdy), .alloc_dst(alloc_dst),
        .full(full), .bc_valid(bc_valid), .bc_tag(bc_tag), .issue(issue),
        .slot_valid(slot_valid), .slot_ready(slot_ready), .slot_dst(slot_dst)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Cycle model of the requirements.
    logic          m_v [D], m_ra [D], m_rb [D];
    logic [TW-1:0] m_sa [D], m_sb [D], m_d [D];
    logic          bq_v [NG];
    logic [TW-1:0] bq_t [NG];

    task automatic chk(string req, string what, logic [255:0] act, logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int j = 0; j < D; j++) begin
            m_v[j] = 0; m_ra[j] = 0; m_rb[j] = 0; m_sa[j] = 0; m_sb[j] = 0; m_d[j] = 0;
        end
        for (int k = 0; k < NG; k++) begin bq_v[k] = 0; bq_t[k] = 0; end
    endtask

    task automatic model_step();
        logic          nv [D], nra [D], nrb [D];
        logic [TW-1:0] nsa [D], nsb [D], nd [D];
        logic          sv [NG];
        logic [TW-1:0] st [NG];
        logic          fullm, hole;
        fullm = 1'b1;
        for (int j = 0; j < D; j++) fullm = fullm & m_v[j];
        sv[0] = bc_valid; st[0] = bc_tag;
        for (int k = 1; k < NG; k++) begin sv[k] = bq_v[k]; st[k] = bq_t[k]; end
        hole = 1'b0;
        for (int j = 0; j < D; j++) begin
            int src;
            hole = hole | ~m_v[j];
            src  = hole ? j + 1 : j;
            if (src == D) begin
                nv[j] = alloc_valid & ~fullm; nra[j] = alloc_src_a_rdy; nrb[j] = alloc_src_b_rdy;
                nsa[j] = alloc_src_a; nsb[j] = alloc_src_b; nd[j] = alloc_dst;
            end else begin
                nv[j] = m_v[src] & ~issue[src]; nra[j] = m_ra[src]; nrb[j] = m_rb[src];
                nsa[j] = m_sa[src]; nsb[j] = m_sb[src]; nd[j] = m_d[src];
            end
            for (int k = 0; k < NG; k++) begin
                if ((k == j / G) || (src != D && k == src / G)) begin
                    if (sv[k] && st[k] == nsa[j]) nra[j] = 1'b1;
                    if (sv[k] && st[k] == nsb[j]) nrb[j] = 1'b1;
                end
            end
        end
        for (int j = 0; j < D; j++) begin
            m_v[j] = nv[j]; m_ra[j] = nra[j]; m_rb[j] = nrb[j];
            m_sa[j] = nsa[j]; m_sb[j] = nsb[j]; m_d[j] = nd[j];
        end
        for (int k = NG - 1; k >= 1; k--) begin bq_v[k] = sv[k-1]; bq_t[k] = st[k-1]; end
    endtask

    task automatic compare();
        logic [D-1:0]    ev, er;
        logic [D*TW-1:0] ed, ad;
        logic            ef;
        ef = 1'b1;
        for (int j = 0; j < D; j++) begin
            ev[j] = m_v[j];
            er[j] = m_v[j] & m_ra[j] & m_rb[j];
            ed[j*TW +: TW] = m_v[j] ? m_d[j] : '0;
            ad[j*TW +: TW] = slot_valid[j] ? slot_dst[j*TW +: TW] : '0;
            ef = ef & m_v[j];
        end
        chk("R3", "model slot_valid", 256'(slot_valid), 256'(ev));
        chk("R6", "model slot_ready", 256'(slot_ready), 256'(er));
        chk("R2", "model slot_dst", 256'(ad), 256'(ed));
        chk("R4", "model full", 256'(full), 256'(ef));
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        if (rst) model_reset(); else model_step();
        compare();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic put(logic [TW-1:0] sa, logic ra, logic [TW-1:0] sb, logic rb, logic [TW-1:0] d);
        alloc_valid = 1; alloc_src_a = sa; alloc_src_a_rdy = ra;
        alloc_src_b = sb; alloc_src_b_rdy = rb; alloc_dst = d;
    endtask

    function automatic logic [TW-1:0] dst_of(int j);
        return slot_dst[j*TW +: TW];
    endfunction

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        logic [TW-1:0] keep;
        void'($urandom(32'd7319));
        model_reset();
        idle(2);
        chk("R1", "reset valid", 256'(slot_valid), 256'(0));
        chk("R1", "reset ready/full", 256'({slot_ready, full}), 256'(0));
        rst = 0;
        tick();
        chk("R1", "first cycle empty", 256'(slot_valid), 256'(0));

        // R2 / R8: single ready instruction written at the tail.
        put(1, 1, 2, 1, 5); tick(); alloc_valid = 0;
        chk("R2", "tail write valid", 256'(slot_valid), 256'(32'h8000_0000));
        chk("R2", "tail write dst", 256'(dst_of(31)), 256'(5));
        chk("R8", "flags stored ready", 256'(slot_ready[31]), 256'(1));
        idle(31);
        chk("R3", "drifted to head", 256'(slot_valid), 256'(1));
        chk("R3", "head dst", 256'(dst_of(0)), 256'(5));

        // R5: issue at head, entry above fills next edge.
        put(3, 1, 4, 1, 6); tick(); alloc_valid = 0;
        idle(32);
        chk("R3", "pair parked", 256'(slot_valid), 256'(3));
        issue = 32'h1; tick(); issue = 0;
        chk("R5", "issued slot empty, no refill", 256'(slot_valid), 256'(2));
        tick();
        chk("R5", "refill next edge", 256'(slot_valid), 256'(1));
        chk("R3", "refill dst", 256'(dst_of(0)), 256'(6));
        issue = 32'h1; tick(); issue = 0;

        // R6: head group sees a broadcast in the cycle it arrives.
        put(9, 0, 4, 1, 7); tick(); alloc_valid = 0;
        idle(32);
        chk("R7", "waiting not ready", 256'(slot_ready[0]), 256'(0));
        bc_valid = 1; bc_tag = 9; tick(); bc_valid = 0;
        chk("R6", "group 0 same cycle", 256'(slot_ready[0]), 256'(1));
        issue = 32'h1; tick(); issue = 0;

        // R9: entry crossing from group 3 into group 2 while the tag is between them.
        put(12, 0, 4, 1, 8); tick(); alloc_valid = 0;
        idle(4);
        bc_valid = 1; bc_tag = 12; tick(); bc_valid = 0;
        idle(2);
        chk("R9", "before crossing", 256'({slot_valid[24], slot_ready[24]}), 256'(2'b10));
        tick();
        chk("R9", "caught while crossing", 256'({slot_valid[23], slot_ready[23]}), 256'(2'b11));
        idle(32); issue = 32'h1; tick(); issue = 0;

        // R10: broadcast three cycles before allocation is caught.
        bc_valid = 1; bc_tag = 20; tick(); bc_valid = 0;
        idle(2);
        put(20, 0, 4, 1, 9); tick(); alloc_valid = 0;
        chk("R10", "three-cycle window caught", 256'(slot_ready[31]), 256'(1));
        idle(32); issue = 32'h1; tick(); issue = 0;

        // R10: four cycles before is not seen.
        bc_valid = 1; bc_tag = 21; tick(); bc_valid = 0;
        idle(3);
        put(21, 0, 4, 1, 10); tick(); alloc_valid = 0;
        idle(4);
        chk("R10", "four-cycle broadcast missed", 256'(slot_ready), 256'(0));
        idle(32); issue = 32'h1; tick(); issue = 0;

        // R4 / R6: fill the queue, all waiting on tag 30.
        for (int i = 0; i < 200 && !full; i++) begin
            put(30, 0, 4, 1, TW'(i)); tick();
        end
        alloc_valid = 0;
        chk("R4", "full when all valid", 256'({full, slot_valid}), 256'({1'b1, 32'hFFFF_FFFF}));
        keep = dst_of(31);
        put(1, 1, 1, 1, 63); tick(); alloc_valid = 0;
        chk("R4", "alloc while full dropped", 256'(dst_of(31)), 256'(keep));
        bc_valid = 1; bc_tag = 30; tick(); bc_valid = 0;
        chk("R6", "group 0 wakes", 256'(slot_ready), 256'(32'h0000_00FF));
        tick();
        chk("R6", "group 1 wakes", 256'(slot_ready), 256'(32'h0000_FFFF));
        tick();
        chk("R6", "group 2 wakes", 256'(slot_ready), 256'(32'h00FF_FFFF));
        tick();
        chk("R6", "group 3 wakes", 256'(slot_ready), 256'(32'hFFFF_FFFF));
        issue = '1; tick(); issue = 0;
        chk("R5", "all issued", 256'(slot_valid), 256'(0));

        // Random traffic against the model.
        for (int n = 0; n < 4000; n++) begin
            alloc_valid     = ($urandom % 10) < 6;
            alloc_src_a     = TW'($urandom % 16);
            alloc_src_b     = TW'($urandom % 16);
            alloc_src_a_rdy = ($urandom % 4) == 0;
            alloc_src_b_rdy = ($urandom % 4) == 0;
            alloc_dst       = TW'($urandom);
            bc_valid        = ($urandom % 2) == 0;
            bc_tag          = TW'($urandom % 16);
            issue           = $urandom & $urandom & $urandom & slot_valid;
            tick();
        end
        alloc_valid = 0; bc_valid = 0; issue = 0;
        tick();
        summary();
    end
endmodule